// File: doc/BRIEF.md
# I2C Master Transfer Length Sequencer

This block counts the bytes of one I2C master transfer segment and decides what happens when the count runs out. Software writes a byte count of 0 to 255 together with two end-mode bits, reload and auto-stop. A separate shift engine reports each finished byte on a valid/ready handshake. When the last byte of a segment is accepted, the block does one of three things: it raises a completion flag and stalls the bus clock, it raises a refill flag and stalls, or it fires a one-cycle STOP request.

It also holds a checksum-byte request. Software can only set this request. Hardware clears it when the checksum byte has gone out, when a STOP or an address match is seen, when the block is disabled, or when a software reset is applied. While checksum is requested and reload is off, the last byte of the segment is marked as the checksum byte.

Byte handshake rules: `byte_ready` is held low while the clock stall is active or no bytes remain. The shift engine must keep `byte_valid` high until it sees `byte_ready`. A byte counts only on a cycle where both signals are high. In slave mode with byte control disabled, `byte_ready` is held high and every byte is accepted and ignored.

Top module: `i2c_len_seq`

## Requirements
- R1: An accepted configuration write loads the 8-bit `cfg_count` into `remaining` on the next clock. Each accepted byte handshake decrements `remaining` by one.
- R2: With reload=0 and auto-stop=0, accepting the last byte sets `done_flag`, drives `scl_hold` high and `byte_ready` low. `start_req` or `stop_req` clears `done_flag` and releases the hold on the next clock.
- R3: With reload=0 and auto-stop=1, `stop_gen` is high for exactly the one cycle after the last byte is accepted. No flag is raised and `scl_hold` stays low.
- R4: With reload=1, accepting the last byte sets `refill_flag` and `scl_hold`, whatever the auto-stop bit is. The next accepted configuration write clears `refill_flag`. `done_flag` and `refill_flag` are never high together.
- R5: A `pec_wr` with `pec_wdata`=1 sets `pec_req`. A `pec_wr` with `pec_wdata`=0 leaves `pec_req` unchanged.
- R6: `pec_req` clears on the clock after `stop_seen` or `addr_match`. It also clears after the last byte is accepted with reload=0, because that byte is the checksum byte. A clear takes priority over a set in the same cycle.
- R7: While reload=1, `pec_req` does not mark a checksum byte and is not cleared at the end of the count.
- R8: `pec_last` is high while `pec_req`=1, reload=0 and `remaining`=1.
- R9: A configuration write while `start_pend`=1 leaves `remaining` unchanged. The mode bits are still updated.
- R10: With `master_mode`=0 and `byte_ctl_en`=0: `byte_ready`=1, bytes do not change `remaining`, no flag or `stop_gen` is produced, and `pec_wr` is ignored.
- R11: `enable`=0 or `soft_rst`=1 clears `remaining`, both flags, `stop_gen` and `pec_req` on the next clock.
- R12: While counting, `byte_ready` is low when `remaining`=0 or `scl_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low clears all state |
| soft_rst | input | 1 | Software reset strobe |
| master_mode | input | 1 | High when acting as bus master |
| byte_ctl_en | input | 1 | Byte control enable in slave mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_count | input | 8 | Segment byte count |
| cfg_reload | input | 1 | Reload mode bit |
| cfg_autostop | input | 1 | Auto-stop mode bit |
| start_pend | input | 1 | A START request is pending |
| start_req | input | 1 | Software START / repeated START strobe |
| stop_req | input | 1 | Software STOP strobe |
| pec_wr | input | 1 | Checksum request write strobe |
| pec_wdata | input | 1 | Checksum request write value |
| stop_seen | input | 1 | STOP condition observed on bus |
| addr_match | input | 1 | Own address matched |
| byte_valid | input | 1 | Shift engine finished a byte |
| byte_ready | output | 1 | Sequencer accepts the byte |
| remaining | output | 8 | Bytes left in segment |
| done_flag | output | 1 | Transfer complete, software end |
| refill_flag | output | 1 | Count exhausted in reload mode |
| scl_hold | output | 1 | Stretch SCL low |
| stop_gen | output | 1 | One-cycle STOP request |
| pec_req | output | 1 | Checksum byte requested |
| pec_last | output | 1 | Current byte is the checksum byte |

## Verification
The assertions check these rules on every cycle:
- the two flags are mutually exclusive;
- `stop_gen` never coincides with a stall and lasts a single cycle;
- a count write during a pending START keeps the count;
- bus events clear the checksum request, and a write of zero never changes it;
- disabling the block empties all state.

Only the bench scenarios can show the following:
- which end action each combination of mode bits selects;
- the exact cycle of the checksum-byte mark;
- how the flags are released by software strobes;
- that slave mode without byte control stays silent.

// File: rtl/i2c_len_pkg.sv
package i2c_len_pkg;
  typedef enum logic [1:0] {
    END_SW     = 2'd0,
    END_AUTO   = 2'd1,
    END_REFILL = 2'd2
  } end_mode_e;

  function automatic end_mode_e pick_mode(input logic reload, input logic autostop);
    if (reload)        return END_REFILL;
    else if (autostop) return END_AUTO;
    else               return END_SW;
  endfunction
endpackage

// File: rtl/i2c_len_counter.sv
module i2c_len_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] remaining,
  output logic             at_one,
  output logic             last_step
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remaining <= '0;
    else if (clr)           remaining <= '0;
    else if (load)          remaining <= load_val;
    else if (step)          remaining <= remaining - ONE;
  end

  assign at_one    = (remaining == ONE);
  assign last_step = step && at_one && !load && !clr;
endmodule

// File: rtl/i2c_len_endctl.sv
module i2c_len_endctl
  import i2c_len_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode_wr,
  input  logic cfg_reload,
  input  logic cfg_autostop,
  input  logic count_loaded,
  input  logic last_step,
  input  logic start_req,
  input  logic stop_req,
  output logic reload_q,
  output logic done_flag,
  output logic refill_flag,
  output logic stop_gen
);
  logic      autostop_q;
  end_mode_e mode;

  assign mode = pick_mode(reload_q, autostop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q   <= 1'b0;
      autostop_q <= 1'b0;
    end else if (clr) begin
      reload_q   <= 1'b0;
      autostop_q <= 1'b0;
    end else if (mode_wr) begin
      reload_q   <= cfg_reload;
      autostop_q <= cfg_autostop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag   <= 1'b0;
      refill_flag <= 1'b0;
      stop_gen    <= 1'b0;
    end else if (clr) begin
      done_flag   <= 1'b0;
      refill_flag <= 1'b0;
      stop_gen    <= 1'b0;
    end else begin
      stop_gen <= last_step && (mode == END_AUTO);
      if (last_step && mode == END_SW)         done_flag <= 1'b1;
      else if (start_req || stop_req)          done_flag <= 1'b0;
      if (last_step && mode == END_REFILL)     refill_flag <= 1'b1;
      else if (count_loaded)                   refill_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_len_pec.sv
module i2c_len_pec (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic counting,
  input  logic pec_wr,
  input  logic pec_wdata,
  input  logic stop_seen,
  input  logic addr_match,
  input  logic reload_q,
  input  logic at_one,
  input  logic last_step,
  output logic pec_req,
  output logic pec_last
);
  logic hw_clear;

  assign hw_clear = clr || stop_seen || addr_match || (last_step && !reload_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pec_req <= 1'b0;
    else if (hw_clear)                         pec_req <= 1'b0;
    else if (pec_wr && pec_wdata && counting)  pec_req <= 1'b1;
  end

  assign pec_last = pec_req && !reload_q && at_one && counting;
endmodule

// File: rtl/i2c_len_seq.sv
module i2c_len_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_rst,
  input  logic             master_mode,
  input  logic             byte_ctl_en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_reload,
  input  logic             cfg_autostop,
  input  logic             start_pend,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             pec_wr,
  input  logic             pec_wdata,
  input  logic             stop_seen,
  input  logic             addr_match,
  input  logic             byte_valid,
  output logic             byte_ready,
  output logic [CNT_W-1:0] remaining,
  output logic             done_flag,
  output logic             refill_flag,
  output logic             scl_hold,
  output logic             stop_gen,
  output logic             pec_req,
  output logic             pec_last
);
  logic clr, counting, load, step, at_one, last_step, reload_q;

  assign clr      = soft_rst || !enable;
  assign counting = master_mode || byte_ctl_en;
  assign load     = cfg_wr && !start_pend && counting && !clr;
  assign scl_hold = done_flag || refill_flag;
  assign byte_ready = counting ? ((remaining != '0) && !scl_hold) : 1'b1;
  assign step     = byte_valid && byte_ready && counting;

  i2c_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(cfg_count),
    .step(step), .remaining(remaining), .at_one(at_one), .last_step(last_step)
  );

  i2c_len_endctl u_end (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_wr(cfg_wr && counting),
    .cfg_reload(cfg_reload), .cfg_autostop(cfg_autostop), .count_loaded(load),
    .last_step(last_step), .start_req(start_req), .stop_req(stop_req),
    .reload_q(reload_q), .done_flag(done_flag), .refill_flag(refill_flag),
    .stop_gen(stop_gen)
  );

  i2c_len_pec u_pec (
    .clk(clk), .rst_n(rst_n), .clr(clr), .counting(counting), .pec_wr(pec_wr),
    .pec_wdata(pec_wdata), .stop_seen(stop_seen), .addr_match(addr_match),
    .reload_q(reload_q), .at_one(at_one), .last_step(last_step),
    .pec_req(pec_req), .pec_last(pec_last)
  );
endmodule

// File: rtl/i2c_len_seq_chk.sv
module i2c_len_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             soft_rst,
  input logic             cfg_wr,
  input logic             start_pend,
  input logic             pec_wr,
  input logic             pec_wdata,
  input logic             stop_seen,
  input logic             addr_match,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic [CNT_W-1:0] remaining,
  input logic             done_flag,
  input logic             refill_flag,
  input logic             scl_hold,
  input logic             stop_gen,
  input logic             pec_req
);
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_flag, refill_flag}));

  p_stop_no_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_gen |-> !scl_hold);

  p_stop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_gen |=> !stop_gen);

  p_start_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && start_pend && !(byte_valid && byte_ready) && enable && !soft_rst)
      |=> remaining == $past(remaining));

  p_pec_bus_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen || addr_match) |=> !pec_req);

  p_pec_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_wr && !pec_wdata && !(byte_valid && byte_ready)) |=> !$rose(pec_req));

  p_disable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || soft_rst) |=> (remaining == '0 && !done_flag && !refill_flag && !pec_req && !stop_gen));
endmodule

bind i2c_len_seq i2c_len_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
  .start_pend(start_pend), .pec_wr(pec_wr), .pec_wdata(pec_wdata),
  .stop_seen(stop_seen), .addr_match(addr_match), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .remaining(remaining), .done_flag(done_flag),
  .refill_flag(refill_flag), .scl_hold(scl_hold), .stop_gen(stop_gen),
  .pec_req(pec_req)
);

// File: tb/i2c_len_seq_test.sv
module i2c_len_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // fields: count[13:6] reload[5] autostop[4] pec[3] exp_done[2] exp_refill[1] exp_stop[0]
  localparam logic [NV-1:0][13:0] VEC = {
    {8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic enable = 0, soft_rst = 0, master_mode = 1, byte_ctl_en = 0;
  logic cfg_wr = 0, cfg_reload = 0, cfg_autostop = 0, start_pend = 0;
  logic [7:0] cfg_count = 0;
  logic start_req = 0, stop_req = 0, pec_wr = 0, pec_wdata = 0;
  logic stop_seen = 0, addr_match = 0, byte_valid = 0;
  logic byte_ready, done_flag, refill_flag, scl_hold, stop_gen, pec_req, pec_last;
  logic [7:0] remaining;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_len_seq uut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_cfg(logic [7:0] c, logic rl, logic au);
    cfg_wr = 1; cfg_count = c; cfg_reload = rl; cfg_autostop = au;
    tick();
    cfg_wr = 0;
  endtask

  task automatic feed_byte();
    byte_valid = 1;
    tick();
    byte_valid = 0;
  endtask

  task automatic sreset();
    soft_rst = 1; tick(); soft_rst = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; enable = 1;
    tick();
    check("R11 reset remaining", remaining, 0);
    check("R11 reset flags", {done_flag, refill_flag, stop_gen, pec_req}, 0);
    check("R12 ready low when empty", byte_ready, 0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      logic rl, au, pc, ed, er, es;
      {c, rl, au, pc, ed, er, es} = VEC[i];
      sreset();
      write_cfg(c, rl, au);
      check("R1 load count", remaining, c);
      if (pc) begin
        pec_wr = 1; pec_wdata = 1; tick(); pec_wr = 0;
        check("R5 pec set", pec_req, 1);
      end
      for (int b = c; b > 0; b--) begin
        check("R12 ready while counting", byte_ready, 1);
        if (b == 1) check("R8 R7 pec_last on last byte", pec_last, pc && !rl);
        else        check("R8 pec_last early", pec_last, 0);
        feed_byte();
        if (b > 1) check("R1 decrement", remaining, b - 1);
      end
      check("R2 done flag", done_flag, ed);
      check("R4 refill flag", refill_flag, er);
      check("R3 stop pulse", stop_gen, es);
      check("R2 R4 hold", scl_hold, ed || er);
      check("R6 R7 pec after end", pec_req, pc && rl);
      tick();
      check("R3 stop one cycle", stop_gen, 0);
      check("R12 ready low after end", byte_ready, 0);
    end

    // R2 release by stop_req / start_req
    sreset(); write_cfg(8'd1, 0, 0); feed_byte();
    check("R2 done set", done_flag, 1);
    stop_req = 1; tick(); stop_req = 0;
    check("R2 stop_req clears", {done_flag, scl_hold}, 0);
    write_cfg(8'd1, 0, 0); feed_byte();
    start_req = 1; tick(); start_req = 0;
    check("R2 start_req clears", done_flag, 0);

    // R4 refill cleared by new count
    sreset(); write_cfg(8'd1, 1, 0); feed_byte();
    check("R4 refill set", refill_flag, 1);
    write_cfg(8'd2, 1, 0);
    check("R4 refill cleared on write", {refill_flag, scl_hold}, 0);
    check("R4 new count", remaining, 2);

    // R9 write during pending start
    start_pend = 1; write_cfg(8'd9, 0, 0); start_pend = 0;
    check("R9 count kept", remaining, 2);

    // R5 zero write, R6 bus clears
    sreset(); write_cfg(8'd3, 0, 0);
    pec_wr = 1; pec_wdata = 0; tick(); pec_wr = 0;
    check("R5 zero write no set", pec_req, 0);
    pec_wr = 1; pec_wdata = 1; tick();
    pec_wdata = 0; tick(); pec_wr = 0;
    check("R5 zero write no clear", pec_req, 1);
    stop_seen = 1; tick(); stop_seen = 0;
    check("R6 stop_seen clears", pec_req, 0);
    pec_wr = 1; pec_wdata = 1; tick(); pec_wr = 0;
    addr_match = 1; tick(); addr_match = 0;
    check("R6 addr_match clears", pec_req, 0);
    pec_wr = 1; pec_wdata = 1; addr_match = 1; tick(); pec_wr = 0; addr_match = 0;
    check("R6 clear beats set", pec_req, 0);

    // R11 enable low
    pec_wr = 1; pec_wdata = 1; tick(); pec_wr = 0;
    enable = 0; tick(); enable = 1;
    check("R11 enable low clears", {remaining, pec_req}, 0);

    // R10 slave without byte control
    write_cfg(8'd2, 0, 0);
    master_mode = 0; byte_ctl_en = 0;
    check("R10 ready high", byte_ready, 1);
    feed_byte(); feed_byte(); feed_byte();
    check("R10 count untouched", remaining, 2);
    check("R10 no flags", {done_flag, refill_flag, stop_gen, scl_hold}, 0);
    pec_wr = 1; pec_wdata = 1; tick(); pec_wr = 0;
    check("R10 pec ignored", pec_req, 0);
    byte_ctl_en = 1; feed_byte();
    check("R10 byte control counts", remaining, 1);
    master_mode = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule